// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose producer and consumer run on two unrelated clocks. Either clock may be the faster one. Words are taken on the write clock and handed out on the read clock. Each side keeps a binary pointer, and each pointer crosses into the other clock domain as a Gray code through a two-stage synchronizer. Every status flag is therefore computed only from registers in one domain.

Two presentation modes are available, and the choice is latched while master reset is held. In request mode every word, the first one included, needs a read enable before it appears on the output. In fall-through mode the oldest word is moved to the output register on its own, and a ready flag shows that it is there. Two thresholds can be programmed: one for the almost-empty flag and one for the almost-full flag. They are loaded in parallel from the data bus or serially one bit at a time, and each takes one of two defaults at master reset. Partial reset empties the buffer but keeps the mode and the thresholds. Retransmit rewinds the read side to the first location so that the stored data can be read a second time.

Top module: `xclk_fifo`

## Requirements
- R1: While mstRstN is low, fwftSel and offSel are sampled on each write-clock edge. After master reset the buffer is empty. In request mode (fwftSel=0) rdStatus=1 and wrStatus=0. In fall-through mode (fwftSel=1) rdStatus=0 and wrStatus=1. In both modes almostEmpty=1, almostFull=0 and halfFull=0.
- R2: Words leave in the order they were written. In request mode a word, the first one included, reaches rdData only after the read-clock edge that samples rdEn=1 while rdStatus=0. In request mode rdStatus=1 means the buffer is empty.
- R3: In fall-through mode the oldest stored word is loaded into the output without any rdEn, and rdStatus=1 means a word is on rdData. rdEn=1 on a read edge consumes that word and brings in the next one, if there is one. In this mode wrStatus=1 means there is room for another write.
- R4: A write while the buffer holds DEPTH words is dropped, and so is a read while it is empty. Neither moves a pointer, and a dropped read leaves rdData unchanged. In request mode wrStatus=1 means full.
- R5: halfFull=1 while the write side counts more than DEPTH/2 stored words.
- R6: almostEmpty=1 while the read-side count is at most the empty threshold. In fall-through mode that count includes the presented word. almostFull=1 while the write-side count is at least DEPTH minus the full threshold.
- R7: At master reset, offSel=0 sets both thresholds to NEAR_OFFSET (default 8), and offSel=1 sets both to FAR_OFFSET (default 64).
- R8: Parallel load: each write-clock edge with loadEn=1 and serialMode=0 takes wrData[AW-1:0]. The first such edge after any reset sets the empty threshold, the next one sets the full threshold, and the two alternate from then on. No word is stored while loadEn=1.
- R9: Serial load: each write-clock edge with loadEn=1 and serialMode=1 shifts in serialIn. After 2*AW shifts, the first AW bits form the empty threshold and the next AW bits form the full threshold, each least significant bit first.
- R10: A low prtRstN empties the buffer and clears both pointers. It keeps the thresholds and the mode.
- R11: A read-clock edge with retransmit=1 sets the read pointer to location 0. Later reads return the stored words again from the first one written, provided at most DEPTH words have been written since the last reset.
- R12: With outEn=0, rdData is IDLE_WORD (default 0).
- R13: Writes and reads run at the same time on independent clocks. wrStatus, halfFull and almostFull change on the write clock. rdStatus and almostEmpty change on the read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mstRstN | input | 1 | Master reset, active low, synchronous in each domain |
| prtRstN | input | 1 | Partial reset, active low |
| fwftSel | input | 1 | Mode select (1 = fall-through), sampled during master reset |
| offSel | input | 1 | Default threshold select, sampled during master reset |
| wrEn | input | 1 | Write enable |
| wrData | input | 18 | Write data, also the parallel threshold value |
| loadEn | input | 1 | Threshold load enable |
| serialMode | input | 1 | 1 = serial threshold load, 0 = parallel |
| serialIn | input | 1 | Serial threshold bit |
| rdEn | input | 1 | Read enable |
| outEn | input | 1 | Output enable |
| retransmit | input | 1 | Rewind the read pointer to location 0 |
| rdData | output | 18 | Read data |
| rdStatus | output | 1 | Empty (request mode) or output ready (fall-through mode) |
| wrStatus | output | 1 | Full (request mode) or input ready (fall-through mode) |
| halfFull | output | 1 | More than half full |
| almostEmpty | output | 1 | At or below the empty threshold |
| almostFull | output | 1 | At or above DEPTH minus the full threshold |

## Verification
The writer and the reader can be active in the same cycle, and they are the two functions whose meeting matters most. In that case the read side compares a Gray pointer that is in the middle of synchronization against its own pointer. To provoke this, the bench forks a writer on the 8 ns clock and a reader on an unrelated 11 ns clock. The reader pulls a word whenever rdStatus shows data, so edges of the two clocks often land close together. The test is judged by comparing every word received against the written sequence, in order, with nothing lost or repeated.

// File: rtl/xff_pkg.sv
package xff_pkg;
  localparam int ADDR_MAX = 16;

  typedef struct packed {
    logic                wrStb;
    logic [ADDR_MAX-1:0] wrAddr;
    logic                rdStb;
    logic [ADDR_MAX-1:0] rdAddr;
  } xffStrobe_t;
endpackage

// File: rtl/xff_sync.sv
module xff_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/xff_ctrl.sv
module xff_ctrl
  import xff_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int AW          = 10,
  parameter int NEAR_OFFSET = 8,
  parameter int FAR_OFFSET  = 64
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mstRstN,
  input  logic             prtRstN,
  input  logic             fwftSel,
  input  logic             offSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             loadEn,
  input  logic             serialMode,
  input  logic             serialIn,
  input  logic             rdEn,
  input  logic             retransmit,
  output xffStrobe_t       strb,
  output logic             rdRst,
  output logic             rdStatus,
  output logic             wrStatus,
  output logic             halfFull,
  output logic             almostEmpty,
  output logic             almostFull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstAny;
  assign rstAny = !mstRstN || !prtRstN;
  assign rdRst  = rstAny;

  // ---------------- configuration (write domain) ----------------
  logic          fwftMode;
  logic [AW-1:0] aeOff, afOff;
  logic          loadPhase;
  logic [2*AW-1:0] offCat;
  assign offCat = {afOff, aeOff};

  always_ff @(posedge wrClk) begin
    if (!mstRstN) begin
      fwftMode <= fwftSel;
      aeOff    <= offSel ? AW'(FAR_OFFSET) : AW'(NEAR_OFFSET);
      afOff    <= offSel ? AW'(FAR_OFFSET) : AW'(NEAR_OFFSET);
    end else if (prtRstN && loadEn) begin
      if (serialMode) begin
        {afOff, aeOff} <= {serialIn, offCat[2*AW-1:1]};
      end else if (!loadPhase) begin
        aeOff <= wrData[AW-1:0];
      end else begin
        afOff <= wrData[AW-1:0];
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (rstAny) loadPhase <= 1'b0;
    else if (loadEn && !serialMode) loadPhase <= !loadPhase;
  end

  // ---------------- write side ----------------
  logic [PW-1:0] wrPtr, wrGray, rdGraySync, rdSyncBin, wrCount;
  logic [PW-1:0] rdPtr, rdGray, wrGraySync, wrSyncBin, memCount, rdCount;
  logic fullW, wrTake;

  xff_sync #(.W(PW)) uSyncRdToWr (
    .clk (wrClk), .rst (rstAny), .din (rdGray), .dout (rdGraySync)
  );

  assign rdSyncBin = toBin(rdGraySync);
  assign wrCount   = wrPtr - rdSyncBin;
  assign fullW     = (wrCount == DEPTH_P);
  assign wrTake    = wrEn && !loadEn && !fullW;

  always_ff @(posedge wrClk) begin
    if (rstAny) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrTake) begin
      wrPtr  <= wrPtr + 1'b1;
      wrGray <= toGray(wrPtr + 1'b1);
    end
  end

  assign wrStatus   = fwftMode ? !fullW : fullW;
  assign halfFull   = (wrCount > HALF_P);
  assign almostFull = (wrCount >= (DEPTH_P - {1'b0, afOff}));

  // ---------------- read side ----------------
  logic memEmpty, outValid, rdTake;

  xff_sync #(.W(PW)) uSyncWrToRd (
    .clk (rdClk), .rst (rstAny), .din (wrGray), .dout (wrGraySync)
  );

  assign wrSyncBin = toBin(wrGraySync);
  assign memCount  = wrSyncBin - rdPtr;
  assign memEmpty  = (memCount == '0);
  assign rdTake    = !retransmit && !memEmpty &&
                     (fwftMode ? (!outValid || rdEn) : rdEn);

  always_ff @(posedge rdClk) begin
    if (rstAny) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else if (retransmit) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdTake) begin
        rdPtr  <= rdPtr + 1'b1;
        rdGray <= toGray(rdPtr + 1'b1);
      end
      if (fwftMode) outValid <= rdTake || (outValid && !rdEn);
    end
  end

  assign rdCount     = memCount + PW'(fwftMode && outValid);
  assign rdStatus    = fwftMode ? outValid : memEmpty;
  assign almostEmpty = (rdCount <= {1'b0, aeOff});

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strb        = '0;
    strb.wrStb  = wrTake;
    strb.wrAddr = ADDR_MAX'(wrPtr[AW-1:0]);
    strb.rdStb  = rdTake;
    strb.rdAddr = ADDR_MAX'(rdPtr[AW-1:0]);
  end

  // ---------------- assertions ----------------
  initial assert (AW <= ADDR_MAX);

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (rstAny)
    wrCount <= DEPTH_P); // R4
  AST_FULL_HOLDS_PTR: assert property (@(posedge wrClk) disable iff (rstAny)
    fullW |=> $stable(wrPtr)); // R4
  AST_EMPTY_HOLDS_PTR: assert property (@(posedge rdClk) disable iff (rstAny)
    (memEmpty && !retransmit) |=> $stable(rdPtr)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (rstAny)
    memCount <= DEPTH_P); // R13
  AST_GRAY_ONE_STEP: assert property (@(posedge wrClk) disable iff (rstAny)
    $countones(wrGray ^ $past(wrGray)) <= 1); // R13
  AST_RETX_REWINDS: assert property (@(posedge rdClk) disable iff (rstAny)
    retransmit |=> (rdPtr == '0)); // R11
  AST_FWFT_HOLDS_WORD: assert property (@(posedge rdClk) disable iff (rstAny)
    (fwftMode && outValid && !rdEn && !retransmit) |=> outValid); // R3
  AST_LOAD_NO_STORE: assert property (@(posedge wrClk) disable iff (rstAny)
    loadEn |=> $stable(wrPtr)); // R8
endmodule

// File: rtl/xff_data.sv
module xff_data
  import xff_pkg::*;
#(
  parameter int              WIDTH     = 18,
  parameter int              AW        = 10,
  parameter logic [WIDTH-1:0] IDLE_WORD = '0
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rdRst,
  input  xffStrobe_t       strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             outEn,
  output logic [WIDTH-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strb.wrStb) mem[strb.wrAddr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) outReg <= '0;
    else if (strb.rdStb) outReg <= mem[strb.rdAddr[AW-1:0]];
  end

  assign rdData = outEn ? outReg : IDLE_WORD;

  AST_OUT_HELD: assert property (@(posedge rdClk) disable iff (rdRst)
    !strb.rdStb |=> $stable(outReg)); // R4
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xff_pkg::*;
#(
  parameter int               WIDTH       = 18,
  parameter int               AW          = 10,
  parameter int               NEAR_OFFSET = 8,
  parameter int               FAR_OFFSET  = 64,
  parameter logic [WIDTH-1:0] IDLE_WORD   = '0
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mstRstN,
  input  logic             prtRstN,
  input  logic             fwftSel,
  input  logic             offSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             loadEn,
  input  logic             serialMode,
  input  logic             serialIn,
  input  logic             rdEn,
  input  logic             outEn,
  input  logic             retransmit,
  output logic [WIDTH-1:0] rdData,
  output logic             rdStatus,
  output logic             wrStatus,
  output logic             halfFull,
  output logic             almostEmpty,
  output logic             almostFull
);
  xffStrobe_t strb;
  logic       rdRst;

  xff_ctrl #(
    .WIDTH(WIDTH), .AW(AW), .NEAR_OFFSET(NEAR_OFFSET), .FAR_OFFSET(FAR_OFFSET)
  ) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .fwftSel(fwftSel), .offSel(offSel), .wrEn(wrEn), .wrData(wrData),
    .loadEn(loadEn), .serialMode(serialMode), .serialIn(serialIn),
    .rdEn(rdEn), .retransmit(retransmit), .strb(strb), .rdRst(rdRst),
    .rdStatus(rdStatus), .wrStatus(wrStatus), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  xff_data #(.WIDTH(WIDTH), .AW(AW), .IDLE_WORD(IDLE_WORD)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .strb(strb),
    .wrData(wrData), .outEn(outEn), .rdData(rdData)
  );
endmodule

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int DEPTH = 1024;

  logic wrClk = 0, rdClk = 0;
  logic mstRstN = 0, prtRstN = 1, fwftSel = 0, offSel = 0;
  logic wrEn = 0, loadEn = 0, serialMode = 0, serialIn = 0;
  logic rdEn = 0, outEn = 1, retransmit = 0;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic rdStatus, wrStatus, halfFull, almostEmpty, almostFull;

  int nVec = 0, nBad = 0;
  bit finished = 0;

  always #4 wrClk = ~wrClk;
  always #5.5 rdClk = ~rdClk;

  xclk_fifo dut (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .fwftSel(fwftSel), .offSel(offSel), .wrEn(wrEn), .wrData(wrData),
    .loadEn(loadEn), .serialMode(serialMode), .serialIn(serialIn),
    .rdEn(rdEn), .outEn(outEn), .retransmit(retransmit), .rdData(rdData),
    .rdStatus(rdStatus), .wrStatus(wrStatus), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  localparam logic [17:0] VEC [16] = '{
    18'h00001, 18'h3FFFE, 18'h15555, 18'h2AAAA, 18'h0F0F0, 18'h30F0F,
    18'h12345, 18'h2BCDE, 18'h00100, 18'h20000, 18'h1FFFF, 18'h0ABCD,
    18'h3C3C3, 18'h03C3C, 18'h11111, 18'h2EEEE };

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 37 + 5) & 18'h3FFFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
  endtask

  task automatic masterReset(input logic mode, input logic sel);
    @(negedge wrClk);
    mstRstN = 0; fwftSel = mode; offSel = sel;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    mstRstN = 1;
    settle();
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    prtRstN = 0;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    prtRstN = 1;
    settle();
  endtask

  task automatic wr(input logic [17:0] d);
    @(negedge wrClk);
    wrEn = 1; wrData = d;
    @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic rd();
    @(negedge rdClk);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic parLoad(input logic [17:0] v);
    @(negedge wrClk);
    loadEn = 1; serialMode = 0; wrData = v;
    @(negedge wrClk);
    loadEn = 0;
  endtask

  task automatic serLoad(input int ae, input int af);
    for (int i = 0; i < 20; i++) begin
      @(negedge wrClk);
      loadEn = 1; serialMode = 1;
      serialIn = (i < 10) ? ae[i] : af[i-10];
    end
    @(negedge wrClk);
    loadEn = 0; serialMode = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, request mode
    masterReset(0, 0);
    chk("R1 rdStatus", rdStatus, 1);
    chk("R1 wrStatus", wrStatus, 0);
    chk("R1 halfFull", halfFull, 0);
    chk("R1 almostEmpty", almostEmpty, 1);
    chk("R1 almostFull", almostFull, 0);
    chk("R1 rdData", rdData, 0);

    // R2 table walk: write all, then read back in order
    for (int i = 0; i < 16; i++) wr(VEC[i]);
    settle();
    chk("R2 not empty", rdStatus, 0);
    chk("R2 first word needs rdEn", rdData, 0);
    for (int i = 0; i < 16; i++) begin
      rd();
      chk("R2 order", rdData, VEC[i]);
    end
    settle();
    chk("R2 empty after drain", rdStatus, 1);

    // R4 read while empty ignored
    rd();
    chk("R4 empty read keeps data", rdData, VEC[15]);
    wr(18'h0BEEF);
    settle();
    chk("R2 request mode holds output", rdData, VEC[15]);
    rd();
    chk("R4 pointer not moved by empty read", rdData, 18'h0BEEF);

    // R5 R6 R4 fill to full
    masterReset(0, 0);
    for (int i = 0; i < 512; i++) wr(pat(i));
    settle();
    chk("R5 halfFull at DEPTH/2", halfFull, 0);
    wr(pat(512));
    settle();
    chk("R5 halfFull above DEPTH/2", halfFull, 1);
    for (int i = 513; i < 1015; i++) wr(pat(i));
    settle();
    chk("R6 almostFull below", almostFull, 0);
    wr(pat(1015));
    settle();
    chk("R6 almostFull at DEPTH-8", almostFull, 1);
    chk("R4 not yet full", wrStatus, 0);
    for (int i = 1016; i < DEPTH; i++) wr(pat(i));
    settle();
    chk("R4 full", wrStatus, 1);
    wr(18'h3FFFF);
    settle();
    chk("R4 still full", wrStatus, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R4 full contents", rdData, pat(i));
    end
    settle();
    chk("R4 extra write dropped", rdStatus, 1);

    // R13 concurrent write and read
    masterReset(0, 0);
    fork
      begin
        for (int i = 0; i < 100; i++) wr(pat(i + 2000));
      end
      begin
        int got = 0;
        while (got < 100) begin
          @(negedge rdClk);
          if (!rdStatus) begin
            rdEn = 1;
            @(negedge rdClk);
            rdEn = 0;
            chk("R13 concurrent order", rdData, pat(got + 2000));
            got++;
          end
        end
      end
    join
    settle();
    chk("R13 drained", rdStatus, 1);

    // R11 retransmit
    masterReset(0, 0);
    for (int i = 0; i < 5; i++) wr(VEC[i]);
    settle();
    for (int i = 0; i < 3; i++) begin
      rd();
      chk("R11 first pass", rdData, VEC[i]);
    end
    @(negedge rdClk);
    retransmit = 1;
    @(negedge rdClk);
    retransmit = 0;
    settle();
    for (int i = 0; i < 5; i++) begin
      rd();
      chk("R11 replay", rdData, VEC[i]);
    end

    // R8 R10 parallel load then partial reset keeps offsets
    masterReset(0, 0);
    parLoad(18'd20);
    parLoad(18'd30);
    wr(VEC[0]);
    settle();
    chk("R10 data present", rdStatus, 0);
    partialReset();
    chk("R10 emptied", rdStatus, 1);
    for (int i = 0; i < 20; i++) wr(pat(i));
    settle();
    chk("R8 ae threshold kept", almostEmpty, 1);
    wr(pat(20));
    settle();
    chk("R8 ae above threshold", almostEmpty, 0);
    for (int i = 21; i < 993; i++) wr(pat(i));
    settle();
    chk("R8 af below", almostFull, 0);
    wr(pat(993));
    settle();
    chk("R8 af at DEPTH-30", almostFull, 1);

    // R7 far defaults
    masterReset(0, 1);
    for (int i = 0; i < 64; i++) wr(pat(i));
    settle();
    chk("R7 far default ae", almostEmpty, 1);
    wr(pat(64));
    settle();
    chk("R7 far default ae above", almostEmpty, 0);

    // R9 serial load
    masterReset(0, 0);
    serLoad(3, 5);
    for (int i = 0; i < 3; i++) wr(pat(i));
    settle();
    chk("R9 serial ae", almostEmpty, 1);
    wr(pat(3));
    settle();
    chk("R9 serial ae above", almostEmpty, 0);

    // R1 R3 R12 fall-through mode
    masterReset(1, 0);
    chk("R1 fwft rdStatus", rdStatus, 0);
    chk("R1 fwft wrStatus", wrStatus, 1);
    wr(VEC[6]);
    wr(VEC[7]);
    settle();
    chk("R3 fall-through ready", rdStatus, 1);
    chk("R3 fall-through data", rdData, VEC[6]);
    @(negedge rdClk);
    outEn = 0;
    #1;
    chk("R12 idle output", rdData, 0);
    outEn = 1;
    rd();
    settle();
    chk("R3 next word", rdData, VEC[7]);
    rd();
    settle();
    chk("R3 not ready when drained", rdStatus, 0);
    partialReset();
    chk("R10 mode kept", wrStatus, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule